// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block arbitrates among nine maskable interrupt sources on behalf of a CPU. Each source has a byte-wide control register holding a three-bit priority level and a pending flag. Peripherals raise one-cycle request pulses, and the block latches them into the pending flags. Every cycle it selects the strongest pending source whose level is above the processor's current priority level. Selection is blocked altogether while the global interrupt enable is low.

The CPU sees a registered request line together with the index and level of the winning source. A one-cycle acknowledge clears the winner's pending flag. Software reads and writes the control registers over a simple byte bus at fixed addresses. It can change levels and can clear a pending flag, but it can never set one.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every level field and pending flag is 0, and `int_req`, `int_src` and `int_lvl` are all 0.
- R2: The control registers for sources 0 to 8, in that order, sit at bus addresses 0x4A, 0x4D, 0x4E, 0x51, 0x52, 0x53, 0x54, 0x56 and 0x58. Any other address reads 0, and a write to it changes no register.
- R3: Register layout: bits 2:0 hold the level and bit 3 holds the pending flag. `bus_rdata` shows the addressed register in the same cycle, with no clock. Bits 7:4 always read 0, and writes to them are discarded.
- R4: A bus write loads bits 2:0 of the written byte into the addressed source's level at the next clock edge.
- R5: A request pulse on `irq_pulse[i]` sets pending flag i at the next edge. A bus write with bit 3 = 0 clears the flag. A bus write with bit 3 = 1 leaves the flag unchanged.
- R6: If a request pulse arrives in the same cycle as a software clear or an acknowledge of the same source, the flag stays set.
- R7: A source is eligible only when its pending flag is 1, its level is strictly greater than `cpu_ipl`, and `glb_ie` is 1. A source at level 0 is therefore never eligible.
- R8: Among eligible sources the highest level wins. On equal levels the lower source index (lower address) wins.
- R9: `int_req`, `int_src` and `int_lvl` are registers. At each edge they load the arbitration result computed from the register contents as they stand after that edge and from `glb_ie`/`cpu_ipl` as sampled at that edge. When no source is eligible, all three are 0.
- R10: `int_ack` high while `int_req` is 1 clears the pending flag of source `int_src` at the next edge. `int_ack` while `int_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_pulse | input | 9 | Per-source request pulses from peripherals |
| glb_ie | input | 1 | Global maskable interrupt enable |
| cpu_ipl | input | 3 | Processor current priority level |
| int_ack | input | 1 | CPU acknowledge of the presented request |
| int_req | output | 1 | Interrupt request to the CPU |
| int_src | output | 4 | Index of the winning source |
| int_lvl | output | 3 | Level of the winning source |

## Verification
Every register effect is due one edge after its stimulus, and the CPU-side outputs are due at that same edge. A pulse, write or acknowledge presented before edge k shows up in `bus_rdata` and in `int_req`/`int_src`/`int_lvl` right after edge k. A change on `glb_ie` or `cpu_ipl` appears in the outputs at the first edge that samples it. The bench drives inputs just after a rising edge and runs a reference model at each rising edge. It compares the outputs against that model at the following falling edge. Register read-backs are checked combinationally before the next edge, so every check lands one edge after its cause.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_SRC  = 9;
    localparam int LVL_W    = 3;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int PEND_BIT = LVL_W;

    // Byte address of the control register of each source, ascending
    function automatic logic [ADDR_W-1:0] src_addr(input int idx);
        case (idx)
            0: return 8'h4A;
            1: return 8'h4D;
            2: return 8'h4E;
            3: return 8'h51;
            4: return 8'h52;
            5: return 8'h53;
            6: return 8'h54;
            7: return 8'h56;
            8: return 8'h58;
            default: return 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
        logic [NUM_SRC-1:0]            pend;
    } cfg_t;

    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] src;
        logic [LVL_W-1:0] lvl;
    } win_t;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
    parameter int N_SRC = irq_prio_pkg::NUM_SRC,
    parameter int AW    = irq_prio_pkg::ADDR_W
) (
    input  logic [AW-1:0]    addr,
    output logic [N_SRC-1:0] hit
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_hit
        assign hit[i] = (addr == AW'(irq_prio_pkg::src_addr(i)));
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
    parameter int N_SRC = irq_prio_pkg::NUM_SRC,
    parameter int LW    = irq_prio_pkg::LVL_W,
    parameter int IW    = irq_prio_pkg::IDX_W
) (
    input  logic [N_SRC-1:0][LW-1:0] lvl,
    input  logic [N_SRC-1:0]         pend,
    input  logic                     enable,
    input  logic [LW-1:0]            ipl,
    output logic                     win_req,
    output logic [IW-1:0]            win_src,
    output logic [LW-1:0]            win_lvl
);
    logic [LW-1:0] best_lvl;

    always_comb begin
        win_req  = 1'b0;
        win_src  = '0;
        best_lvl = ipl;
        // strict compare keeps the lowest index on a tie
        for (int i = 0; i < N_SRC; i++) begin
            if (enable && pend[i] && (lvl[i] > best_lvl)) begin
                win_req  = 1'b1;
                win_src  = IW'(i);
                best_lvl = lvl[i];
            end
        end
        win_lvl = win_req ? best_lvl : '0;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_pulse,
    input  logic               glb_ie,
    input  logic [LVL_W-1:0]   cpu_ipl,
    input  logic               int_ack,
    output logic               int_req,
    output logic [IDX_W-1:0]   int_src,
    output logic [LVL_W-1:0]   int_lvl
);
    localparam int PAD_W = DATA_W - LVL_W - 1;

    cfg_t cfg_d, cfg_q;
    win_t win_d, win_q;

    logic [NUM_SRC-1:0]            hit;
    logic [NUM_SRC-1:0]            pend_now;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_now;
    logic                          arb_req;
    logic [IDX_W-1:0]              arb_src;
    logic [LVL_W-1:0]              arb_lvl;

    irq_addr_decode #(.N_SRC(NUM_SRC), .AW(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    // Register next state: write, acknowledge, then hardware set wins
    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_we && hit[i]) begin
                cfg_d.lvl[i] = bus_wdata[LVL_W-1:0];
                if (!bus_wdata[PEND_BIT]) cfg_d.pend[i] = 1'b0;
            end
            if (int_ack && win_q.req && (win_q.src == IDX_W'(i)))
                cfg_d.pend[i] = 1'b0;
            if (irq_pulse[i])
                cfg_d.pend[i] = 1'b1;
        end
    end

    irq_prio_arbiter #(.N_SRC(NUM_SRC), .LW(LVL_W), .IW(IDX_W)) u_arb (
        .lvl     (cfg_d.lvl),
        .pend    (cfg_d.pend),
        .enable  (glb_ie),
        .ipl     (cpu_ipl),
        .win_req (arb_req),
        .win_src (arb_src),
        .win_lvl (arb_lvl)
    );

    always_comb begin
        win_d.req = arb_req;
        win_d.src = arb_src;
        win_d.lvl = arb_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            win_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            win_q <= win_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (hit[i]) bus_rdata = {{PAD_W{1'b0}}, cfg_q.pend[i], cfg_q.lvl[i]};
        end
    end

    assign pend_now = cfg_q.pend;
    assign lvl_now  = cfg_q.lvl;
    assign int_req  = win_q.req;
    assign int_src  = win_q.src;
    assign int_lvl  = win_q.lvl;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [NUM_SRC-1:0]            irq_pulse,
    input logic                          glb_ie,
    input logic [LVL_W-1:0]              cpu_ipl,
    input logic                          int_req,
    input logic [IDX_W-1:0]              int_src,
    input logic [LVL_W-1:0]              int_lvl,
    input logic [NUM_SRC-1:0]            pend_now,
    input logic [NUM_SRC-1:0][LVL_W-1:0] lvl_now
);
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:LVL_W+1] == '0);

    assert_req_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> $past(glb_ie));

    assert_req_above_ipl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_lvl > $past(cpu_ipl)));

    assert_winner_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (pend_now[int_src] && (lvl_now[int_src] == int_lvl)));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> (int_src == '0 && int_lvl == '0));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assert_set_only_hw_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_now[i]) |-> $past(irq_pulse[i]));
    end
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse),
    .glb_ie    (glb_ie),
    .cpu_ipl   (cpu_ipl),
    .int_req   (int_req),
    .int_src   (int_src),
    .int_lvl   (int_lvl),
    .pend_now  (pend_now),
    .lvl_now   (lvl_now)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_we = 1'b0;
    logic [8:0] irq_pulse = '0;
    logic       glb_ie = 1'b0;
    logic [2:0] cpu_ipl = '0;
    logic       int_ack = 1'b0;
    logic       int_req;
    logic [3:0] int_src;
    logic [2:0] int_lvl;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (.*);

    // reference model
    int m_lvl[9];
    bit m_pend[9];
    bit e_req;
    int e_src, e_lvl;
    int amap[9] = '{'h4A, 'h4D, 'h4E, 'h51, 'h52, 'h53, 'h54, 'h56, 'h58};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_lvl[i]) begin m_lvl[i] = 0; m_pend[i] = 0; end
            e_req = 0; e_src = 0; e_lvl = 0;
        end else begin
            for (int i = 0; i < 9; i++) begin
                if (bus_we && bus_addr == amap[i]) begin
                    m_lvl[i] = bus_wdata & 7;
                    if (!bus_wdata[3]) m_pend[i] = 0;
                end
                if (int_ack && e_req && e_src == i) m_pend[i] = 0;
                if (irq_pulse[i]) m_pend[i] = 1;
            end
            e_req = 0; e_src = 0; e_lvl = 0;
            for (int lv = 7; lv >= 1 && !e_req; lv--)
                for (int i = 0; i < 9 && !e_req; i++)
                    if (glb_ie && m_pend[i] && m_lvl[i] == lv && lv > cpu_ipl) begin
                        e_req = 1; e_src = i; e_lvl = lv;
                    end
        end
    end

    always @(negedge clk) if (rst_n && !done) begin
        tests++;
        if (int_req !== e_req || int_src !== 4'(e_src) || int_lvl !== 3'(e_lvl)) begin
            fails++;
            $display("FAIL R9 cycle compare: got req=%0b src=%0d lvl=%0d exp req=%0b src=%0d lvl=%0d",
                     int_req, int_src, int_lvl, e_req, e_src, e_lvl);
        end
    end

    task automatic check(string req, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h exp 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1; tick(); bus_we = 0;
    endtask

    task automatic pulse(input logic [8:0] m);
        irq_pulse = m; tick(); irq_pulse = '0;
    endtask

    task automatic rd(string req, input logic [7:0] a, input int exp);
        bus_addr = a; #0.2;
        check(req, bus_rdata, exp);
    endtask

    task automatic outs(string req, int r, int s, int l);
        check({req, " req"}, int_req, r);
        check({req, " src"}, int_src, s);
        check({req, " lvl"}, int_lvl, l);
    endtask

    initial begin
        #(4 * 150000);
        fails++; tests++;
        $display("FAIL watchdog: got timeout exp completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        outs("R1 reset", 0, 0, 0);
        for (int i = 0; i < 9; i++) rd("R1 reset reg", 8'(amap[i]), 0);

        wr(8'h4A, 8'hFD);                        // lvl 5, bit3=1, upper junk
        rd("R3 R4 upper ignored and level loaded", 8'h4A, 8'h05);
        rd("R5 write one does not set", 8'h4A, 8'h05);

        wr(8'h4B, 8'h07);                        // unmapped
        rd("R2 unmapped read", 8'h4B, 0);
        for (int i = 1; i < 9; i++) rd("R2 unmapped write no effect", 8'(amap[i]), 0);

        pulse(9'h008);
        rd("R5 pulse sets pending", 8'h51, 8'h08);
        glb_ie = 1; tick();
        outs("R7 level zero never eligible", 0, 0, 0);

        wr(8'h51, 8'h0C);
        outs("R7 R9 eligible same edge", 1, 3, 4);
        cpu_ipl = 4; tick();
        outs("R7 level equal ipl blocked", 0, 0, 0);
        cpu_ipl = 3; tick();
        outs("R7 level above ipl", 1, 3, 4);
        glb_ie = 0; tick();
        outs("R7 global disable", 0, 0, 0);
        glb_ie = 1;

        wr(8'h4D, 8'h06); wr(8'h53, 8'h06);
        pulse(9'h022);
        outs("R8 tie lowest index", 1, 1, 6);
        wr(8'h56, 8'h07); pulse(9'h080);
        outs("R8 highest level", 1, 7, 7);

        int_ack = 1; tick(); int_ack = 0;
        outs("R10 ack next winner", 1, 1, 6);
        rd("R10 ack cleared", 8'h56, 8'h07);
        int_ack = 1; tick(); int_ack = 0;
        outs("R10 second ack", 1, 5, 6);
        int_ack = 1; tick(); int_ack = 0;
        outs("R10 third ack", 1, 3, 4);

        glb_ie = 0; tick();
        int_ack = 1; tick(); int_ack = 0;
        rd("R10 ack without request ignored", 8'h51, 8'h0C);
        glb_ie = 1; tick();

        bus_addr = 8'h51; bus_wdata = 8'h04; bus_we = 1; irq_pulse = 9'h008;
        tick(); bus_we = 0; irq_pulse = '0;
        rd("R6 pulse beats software clear", 8'h51, 8'h0C);
        int_ack = 1; irq_pulse = 9'h008; tick(); int_ack = 0; irq_pulse = '0;
        rd("R6 pulse beats ack", 8'h51, 8'h0C);
        outs("R6 still requested", 1, 3, 4);

        wr(8'h51, 8'h04);
        rd("R5 software clear", 8'h51, 8'h04);
        outs("R5 cleared no request", 0, 0, 0);

        for (int n = 0; n < 600; n++) begin
            bus_we    = ($urandom % 4) == 0;
            bus_addr  = ($urandom % 3 == 0) ? 8'($urandom) : 8'(amap[$urandom % 9]);
            bus_wdata = 8'($urandom);
            irq_pulse = 9'($urandom) & 9'($urandom);
            int_ack   = ($urandom % 3) == 0;
            glb_ie    = ($urandom % 8) != 0;
            cpu_ipl   = 3'($urandom % 5);
            tick();
        end
        bus_we = 0; irq_pulse = '0; int_ack = 0;
        for (int i = 0; i < 9; i++)
            rd("R3 final readback", 8'(amap[i]), (int'(m_pend[i]) << 3) | m_lvl[i]);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule